// File: doc/BRIEF.md
# Double-Buffered Timer-Based PWM Generator

This block drives one pulse-width-modulated output from a bank of three 8-bit period timers. One of the three timers, picked by a select register, provides the time base. Its 8-bit count forms the upper part of a 10-bit time base. The lower two bits come from a sub-count: this is the clock phase when the prescale is 1:1, and otherwise the top two bits of the prescaler. The output is high while the time base is below the active 10-bit duty value. Each period starts when the selected timer reaches its period register.

The duty value is written into a shadow copy through two write registers, one for the upper eight bits and one for the lower two. The shadow moves into the active compare register only on a period match of the selected timer, so a waveform never mixes two duty values. A sticky match flag records each period match. The output pin is gated by a driver-enable bit. Software can enable the driver only after it has seen the flag once, which gives a clean first period.

Register writes use a single-cycle strobe `wr_en` with `wr_addr` and `wr_data`. Addresses 0 to 2 hold the period of timers 0 to 2. Addresses 3 to 5 control timers 0 to 2: bit 0 enables the timer and bits 2:1 select the prescale. Address 6 holds the upper eight duty bits and address 7 the lower two duty bits in data bits 1:0. Address 8 selects the timer. Any write to address 9 clears the flag. Bit 0 of address 10 enables the output driver.

Top module: `pwm_db_gen`

## Requirements
- R1: After reset `pwm_out` is 0, `pwm_oe` is 0, `match_flag` is 0 and `duty_active` is 0, and all timers are disabled.
- R2: With the selected timer enabled, the period is (P+1)·4·N clocks. P is the period register of that timer. N is 1, 4, 16 or 64 for prescale codes 0, 1, 2 or 3 in bits 2:1 of the timer's control register.
- R3: For an active duty D with 0 < D < 4·(P+1), `pwm_out` is high for exactly D·N clocks in every period.
- R4: With an active duty of 0, `pwm_out` stays low for the whole period.
- R5: With an active duty of at least 4·(P+1), `pwm_out` stays high for the whole period.
- R6: A duty written at address 6 (upper 8 bits) or address 7 (lower 2 bits in data bits 1:0) does not change `duty_active` until the next period match of the selected timer. At that match, `duty_active` takes the full 10-bit shadow value.
- R7: A duty write in the same cycle as a period match leaves `duty_active` at the earlier shadow value. The written value becomes active at the following match.
- R8: `match_flag` is set by every period match of the selected timer and is cleared by any write to address 9. When a set and a clear fall in the same cycle, the set wins.
- R9: `pwm_out` is the internal waveform gated by the driver-enable bit (address 10, bit 0). While that bit is 0, `pwm_out` is 0.
- R10: The select register (address 8, bits 1:0) picks timer 0, 1 or 2 as the time base and flag source. Code 3 picks timer 0.
- R11: While the selected timer is disabled, its count stands still and `pwm_out` and `duty_active` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one oscillator period |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | Gated PWM output pin |
| pwm_oe | output | 1 | Output driver enable |
| match_flag | output | 1 | Sticky period-match flag of the selected timer |
| duty_active | output | 10 | Read-only active compare value |

## Verification
Two things can land on the same clock edge: a register write, and a period match that latches the duty and sets the flag. The bench first syncs to an observed flag rise. It then counts one full period and places a write exactly on the next match edge. A duty write at that edge must leave the old shadow in `duty_active`, with the new value showing up one period later. A flag-clear write at that edge must leave `match_flag` set.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;
  localparam int TMR_W   = 8;
  localparam int FRAC_W  = 2;
  localparam int PS_W    = 2;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int NUM_TMR = 3;
  localparam int DUTY_W  = TMR_W + FRAC_W;
  // sub-count spans 4 * (largest prescale) clocks
  localparam int SUB_W   = FRAC_W + 2 * ((1 << PS_W) - 1);

  localparam logic [ADDR_W-1:0] A_PER0 = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTL0 = 4'd3;
  localparam logic [ADDR_W-1:0] A_DHI  = 4'd6;
  localparam logic [ADDR_W-1:0] A_DLO  = 4'd7;
  localparam logic [ADDR_W-1:0] A_SEL  = 4'd8;
  localparam logic [ADDR_W-1:0] A_FCLR = 4'd9;
  localparam logic [ADDR_W-1:0] A_OE   = 4'd10;

  // last sub-count value of one timer tick: 4 * 4^ps - 1
  function automatic logic [SUB_W-1:0] sub_last(input logic [PS_W-1:0] ps);
    int unsigned n;
    n = 32'd4 << (2 * int'(ps));
    return SUB_W'(n - 1);
  endfunction

  // two low time-base bits: top two bits of the sub-count for this ratio
  function automatic logic [FRAC_W-1:0] frac_of(input logic [SUB_W-1:0] sub,
                                                input logic [PS_W-1:0] ps);
    logic [SUB_W-1:0] s;
    s = sub >> (2 * int'(ps));
    return s[FRAC_W-1:0];
  endfunction

  // waveform level for a given time base and active duty
  function automatic logic pwm_level(input logic [DUTY_W-1:0] base,
                                     input logic [DUTY_W-1:0] duty);
    return base < duty;
  endfunction
endpackage

// File: rtl/pwm_db_timer.sv
module pwm_db_timer
  import pwm_db_pkg::*;
#(
  parameter int TW = TMR_W,
  parameter int SW = SUB_W,
  parameter int PW = PS_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_period,
  input  logic          we_ctrl,
  input  logic [DW-1:0] wr_data,
  output logic [TW-1:0] tmr,
  output logic [FRAC_W-1:0] frac,
  output logic          match_evt
);
  logic [TW-1:0] pr_q, tmr_q;
  logic [SW-1:0] sub_q;
  logic [PW-1:0] ps_q;
  logic          en_q;
  logic          sub_wrap, at_top;

  assign sub_wrap  = sub_q >= sub_last(ps_q);
  assign at_top    = tmr_q >= pr_q;
  assign match_evt = en_q && sub_wrap && at_top;
  assign tmr       = tmr_q;
  assign frac      = frac_of(sub_q, ps_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr_q  <= '0;
      tmr_q <= '0;
      sub_q <= '0;
      ps_q  <= '0;
      en_q  <= 1'b0;
    end else begin
      if (we_period) pr_q <= wr_data[TW-1:0];
      if (we_ctrl) begin
        en_q <= wr_data[0];
        ps_q <= wr_data[PW:1];
      end
      if (en_q) begin
        if (sub_wrap) begin
          sub_q <= '0;
          tmr_q <= at_top ? '0 : tmr_q + 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assert_period_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (tmr_q == '0) && (sub_q == '0));
  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && sub_wrap && !at_top) |=> tmr_q == $past(tmr_q) + 1'b1);
  assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(tmr_q) && $stable(sub_q));
endmodule

// File: rtl/pwm_db_duty.sv
module pwm_db_duty
  import pwm_db_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int DTW = DUTY_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we_hi,
  input  logic           we_lo,
  input  logic [DW-1:0]  wr_data,
  input  logic           latch,
  output logic [DTW-1:0] duty_active
);
  localparam int HI_W = DTW - FRAC_W;
  logic [HI_W-1:0]   sh_hi;
  logic [FRAC_W-1:0] sh_lo;
  logic [DTW-1:0]    act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_hi <= '0;
      sh_lo <= '0;
      act_q <= '0;
    end else begin
      if (we_hi) sh_hi <= wr_data[HI_W-1:0];
      if (we_lo) sh_lo <= wr_data[FRAC_W-1:0];
      if (latch) act_q <= {sh_hi, sh_lo};
    end
  end

  assign duty_active = act_q;

  assert_latch_only_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(act_q));
  assert_latch_old_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> act_q == {$past(sh_hi), $past(sh_lo)});
endmodule

// File: rtl/pwm_db_out.sv
module pwm_db_out
  import pwm_db_pkg::*;
#(
  parameter int DTW = DUTY_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we_oe,
  input  logic           oe_bit,
  input  logic [DTW-1:0] base,
  input  logic [DTW-1:0] duty,
  output logic           pwm_out,
  output logic           pwm_oe
);
  logic wave_q, oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      wave_q <= pwm_level(base, duty);
      if (we_oe) oe_q <= oe_bit;
    end
  end

  assign pwm_out = wave_q & oe_q;
  assign pwm_oe  = oe_q;

  assert_zero_duty_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |=> !wave_q);
endmodule

// File: rtl/pwm_db_gen.sv
module pwm_db_gen
  import pwm_db_pkg::*;
#(
  parameter int NT = NUM_TMR,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          pwm_out,
  output logic          pwm_oe,
  output logic          match_flag,
  output logic [DUTY_W-1:0] duty_active
);
  localparam int SEL_W = $clog2(NT + 1);

  logic [TMR_W-1:0]  tmr_a  [NT];
  logic [FRAC_W-1:0] frac_a [NT];
  logic [NT-1:0]     match_a;
  logic [SEL_W-1:0]  sel_q;
  logic [SEL_W-1:0]  sel_idx;
  logic              sel_match, clr_wr, flag_q;
  logic [DUTY_W-1:0] base;

  for (genvar k = 0; k < NT; k++) begin : g_tmr
    pwm_db_timer u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_period (wr_en && (wr_addr == A_PER0 + AW'(k))),
      .we_ctrl   (wr_en && (wr_addr == A_CTL0 + AW'(k))),
      .wr_data   (wr_data),
      .tmr       (tmr_a[k]),
      .frac      (frac_a[k]),
      .match_evt (match_a[k])
    );
  end

  // out-of-range select codes fall back to timer 0
  assign sel_idx   = (int'(sel_q) < NT) ? sel_q : '0;
  assign sel_match = match_a[sel_idx];
  assign base      = {tmr_a[sel_idx], frac_a[sel_idx]};
  assign clr_wr    = wr_en && (wr_addr == A_FCLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en && (wr_addr == A_SEL)) sel_q <= wr_data[SEL_W-1:0];
      if (sel_match)   flag_q <= 1'b1;
      else if (clr_wr) flag_q <= 1'b0;
    end
  end

  assign match_flag = flag_q;

  pwm_db_duty u_duty (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_hi       (wr_en && (wr_addr == A_DHI)),
    .we_lo       (wr_en && (wr_addr == A_DLO)),
    .wr_data     (wr_data),
    .latch       (sel_match),
    .duty_active (duty_active)
  );

  pwm_db_out u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_oe   (wr_en && (wr_addr == A_OE)),
    .oe_bit  (wr_data[0]),
    .base    (base),
    .duty    (duty_active),
    .pwm_out (pwm_out),
    .pwm_oe  (pwm_oe)
  );

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_match |=> match_flag);
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !sel_match) |=> !match_flag);
  assert_select_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_idx) < NT);
endmodule

// File: tb/pwm_db_gen_test.sv
module pwm_db_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out, pwm_oe, match_flag;
  logic [9:0] duty_active;

  int total = 0;
  int bad = 0;

  typedef struct {
    int    len;
    int    hi;
    string req;
  } exp_t;
  exp_t expq[$];

  logic mon_on = 1'b0;
  logic mon_prev = 1'b0;
  logic armed = 1'b0;
  int   m_len = 0;
  int   m_hi = 0;

  always #5 clk = ~clk;

  pwm_db_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .match_flag(match_flag), .duty_active(duty_active)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_duty(input int d);
    wr(4'd6, 8'(d >> 2));
    wr(4'd7, 8'(d & 3));
  endtask

  task automatic win(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  // clear the flag (retrying if a match hit the clear), then wait for its next rise
  task automatic sync_match();
    wr(4'd9, 8'd0);
    while (match_flag) wr(4'd9, 8'd0);
    while (!match_flag) @(negedge clk);
  endtask

  // driver: push expected periods, then wait for the monitor to consume them
  task automatic expect_periods(input int len, input int hi, input int n, input string req);
    mon_on = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) expq.push_back('{len, hi, req});
    mon_on = 1'b1;
    while (expq.size() != 0) @(negedge clk);
    mon_on = 1'b0;
  endtask

  // monitor: measure rise-to-rise length and high time of pwm_out
  always @(negedge clk) begin
    if (!mon_on) begin
      armed = 1'b0;
      mon_prev = pwm_out;
    end else begin
      if (pwm_out && !mon_prev) begin
        if (armed && expq.size() != 0) begin
          exp_t e;
          e = expq.pop_front();
          check({e.req, " period"}, m_len, e.len);
          check({e.req, " high"}, m_hi, e.hi);
        end
        armed = 1'b1;
        m_len = 1;
        m_hi = 1;
      end else begin
        m_len++;
        if (pwm_out) m_hi++;
      end
      mon_prev = pwm_out;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int h;
    int t;
    logic hold_out;
    logic [9:0] hold_duty;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pwm_out", int'(pwm_out), 0);
    check("R1 pwm_oe", int'(pwm_oe), 0);
    check("R1 flag", int'(match_flag), 0);
    check("R1 duty_active", int'(duty_active), 0);
    rst_n = 1'b1;

    // R6: shadow written, not active before any match
    wr(4'd0, 8'd9);
    set_duty(13);
    wr(4'd8, 8'd0);
    repeat (5) @(negedge clk);
    check("R6 before match", int'(duty_active), 0);
    check("R1 flag still clear", int'(match_flag), 0);
    wr(4'd3, 8'd1);                 // timer 0 on, 1:1
    while (!match_flag) @(negedge clk);
    check("R6 latched at match", int'(duty_active), 13);
    wr(4'd10, 8'd1);

    // R2 R3 across prescales
    expect_periods(40, 13, 3, "R2 R3 1:1");
    wr(4'd3, 8'd3); wr(4'd0, 8'd3); set_duty(5);
    repeat (200) @(negedge clk);
    expect_periods(64, 20, 2, "R2 R3 1:4");
    wr(4'd3, 8'd5); wr(4'd0, 8'd1); set_duty(3);
    repeat (300) @(negedge clk);
    expect_periods(128, 48, 2, "R2 R3 1:16");
    wr(4'd3, 8'd7); wr(4'd0, 8'd0); set_duty(2);
    repeat (600) @(negedge clk);
    expect_periods(256, 128, 2, "R2 R3 1:64");

    // back to 1:1, period 40
    wr(4'd3, 8'd1); wr(4'd0, 8'd9);
    set_duty(0);
    repeat (120) @(negedge clk);
    win(80, h);
    check("R4 zero duty high count", h, 0);
    check("R4 active zero", int'(duty_active), 0);

    set_duty(1023);
    repeat (100) @(negedge clk);
    win(80, h);
    check("R5 full duty high count", h, 80);

    set_duty(13);
    repeat (100) @(negedge clk);
    wr(4'd10, 8'd0);
    win(80, h);
    check("R9 driver off", h, 0);
    check("R9 oe low", int'(pwm_oe), 0);
    wr(4'd10, 8'd1);
    win(80, h);
    check("R9 driver on", h, 26);

    // R11 hold while disabled
    wr(4'd3, 8'd0);
    repeat (3) @(negedge clk);
    hold_out = pwm_out;
    hold_duty = duty_active;
    win(60, h);
    check("R11 output held", h, hold_out ? 60 : 0);
    check("R11 duty held", int'(duty_active), int'(hold_duty));
    wr(4'd3, 8'd1);
    repeat (100) @(negedge clk);

    // R7: duty write on the match edge
    t = 40;
    sync_match();
    repeat (t - 1) @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd6; wr_data = 8'd5;   // shadow becomes 21
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 old shadow latched", int'(duty_active), 13);
    repeat (t) @(negedge clk);
    check("R7 new value next period", int'(duty_active), 21);

    // R8: clear, then clear colliding with set
    sync_match();
    wr(4'd9, 8'd0);
    check("R8 flag cleared", int'(match_flag), 0);
    repeat (t - 3) @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd9; wr_data = 8'd0;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 set wins over clear", int'(match_flag), 1);

    // R10 select timer 1 (period 20), then code 3 -> timer 0
    set_duty(13);
    wr(4'd1, 8'd4);
    wr(4'd4, 8'd1);
    wr(4'd8, 8'd1);
    repeat (100) @(negedge clk);
    expect_periods(20, 13, 2, "R10 timer1");
    wr(4'd8, 8'd3);
    repeat (150) @(negedge clk);
    expect_periods(40, 13, 2, "R10 code3 timer0");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule